// File: doc/BRIEF.md
# SDRAM Read Latency and Byte Mask Pipeline

This block is the data-out path on the device side of a synchronous DRAM model. The array side hands it one internal read word per clock while a read burst runs. The block holds each word for a run-time selectable column latency of two or three clocks, then drives it on a 16-bit data output. The output comes with one enable per byte, so a pad ring can build a tristate bus from it. The same block applies the two byte masks. On reads a mask takes effect two clocks late and floats its byte. On writes a mask takes effect in the same clock and blocks that byte of input data.

The command decoder outside the block gives it pre-decoded strobes: read word valid, burst stop, precharge, write, and a mode-load strobe with the latency code. A burst stop or a precharge stops new words from entering the latency pipe. Words already in flight still come out, and then the output floats one latency later. A write command clears every pending read word at once, which frees the bus for incoming data. The block has no storage array, no address counter and no command decoder.

Top module: `sdram_rdlat_pipe`

## Requirements
- R1: In reset and after reset, `dqOe` is 2'b00 and `dqOut` is zero. The read latency after reset is 3 until a mode load changes it.
- R2: On a clock with `modeLoad` high, a `latCode` of 3'b010 selects latency 2 and 3'b011 selects latency 3. Any other code is ignored and the previous latency stays in force.
- R3: A word presented with `rdWordValid` at rising edge E is driven on `dqOut` with its byte enables set in the cycle that follows edge E+L-1, where L is the latency. It is therefore seen by a receiver at edge E+L. Words of a burst, including a new burst that follows on the next cycle, come out one per cycle in order.
- R4: A read byte mask sampled high at edge E clears that byte's enable in the cycle after edge E+1, whatever the latency. `byteMask[1]` covers bits 15:8 and `byteMask[0]` covers bits 7:0. A byte whose enable is low reads as zero on `dqOut`.
- R5: With `wrStb` high, `wrByteEn[b]` is the inverse of `byteMask[b]` in the same cycle. `wrWordOut` passes the bytes of `wrWordIn` that are enabled and zeroes the masked bytes. With `wrStb` low, both outputs are zero.
- R6: A burst stop at edge E drops any word offered in the same cycle. The L-1 words captured before E still come out, and both enables are low in the cycle after edge E+L-1.
- R7: A precharge strobe cuts off the read output in the same way as a burst stop: the same dropped word and the same cutoff cycle as R6.
- R8: A write strobe at edge E discards all pending read words, and both enables are low in the cycle after edge E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| modeLoad | input | 1 | Load the latency code this cycle |
| latCode | input | 3 | Latency code (3'b010 = 2, 3'b011 = 3) |
| rdWordValid | input | 1 | Internal read word valid |
| rdWord | input | 16 | Internal read word |
| byteMask | input | 2 | Byte masks, bit 1 upper byte, bit 0 lower byte |
| stopStb | input | 1 | Decoded burst stop |
| prechargeStb | input | 1 | Decoded precharge |
| wrStb | input | 1 | Decoded write, data on the same cycle |
| wrWordIn | input | 16 | Write data from the bus |
| dqOut | output | 16 | Read data toward the pads |
| dqOe | output | 2 | Output enable per byte |
| wrWordOut | output | 16 | Masked write data toward the array |
| wrByteEn | output | 2 | Write enable per byte |

## Verification
The stop and precharge cutoff properties assume that the latency is not reloaded while read words are in flight. The stimulus therefore changes the latency code only after the pipe has drained. The properties also treat the strobes as one decoded command per cycle, except for the deliberate overlap of a read word with a stop or precharge. The stimulus never raises a write, a stop and a precharge together. Mask behaviour is checked during bursts, on idle cycles and across the edges of masked write cycles. Each latency is checked both before and after an ignored reserved code.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  localparam int SDQ_MAX_LAT = 3;
  localparam int SDQ_TAP_W   = $clog2(SDQ_MAX_LAT);

  // strobes from control to the datapath
  typedef struct packed {
    logic                 pushValid;  // capture a live read word this cycle
    logic                 flushAll;   // drop every pending read word
    logic [SDQ_TAP_W-1:0] tapSel;     // pipe stage that feeds the output
  } pipeCtl_t;
endpackage

// File: rtl/sdq_ctrl.sv
module sdq_ctrl
  import sdq_pkg::*;
#(
  parameter int MinLat   = 2,
  parameter int MaxLat   = SDQ_MAX_LAT,
  parameter int ResetLat = 3,
  parameter int CodeW    = 3,
  localparam int LatW    = $clog2(MaxLat + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeLoad,
  input  logic [CodeW-1:0] latCode,
  input  logic             rdWordValid,
  input  logic             stopStb,
  input  logic             prechargeStb,
  input  logic             wrStb,
  output pipeCtl_t         ctl,
  output logic [LatW-1:0]  curLat
);

  logic codeOk;

  // a code's value equals the latency it selects; the rest are reserved
  always_comb codeOk = (int'(latCode) >= MinLat) && (int'(latCode) <= MaxLat);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  curLat <= LatW'(ResetLat);
    else if (modeLoad && codeOk) curLat <= LatW'(latCode);
  end

  always_comb begin
    ctl.pushValid = rdWordValid & ~stopStb & ~prechargeStb & ~wrStb;
    ctl.flushAll  = wrStb;
    ctl.tapSel    = SDQ_TAP_W'(curLat - LatW'(1));
  end

  // R2: reserved codes leave the latency untouched
  assert_reserved_keep_R2: assert property (@(posedge clk) disable iff (!rstN)
    modeLoad && ((int'(latCode) < MinLat) || (int'(latCode) > MaxLat)) |=> $stable(curLat));

  // R2: latency always within the legal range
  assert_lat_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (int'(curLat) >= MinLat) && (int'(curLat) <= MaxLat));

endmodule

// File: rtl/sdq_datapath.sv
module sdq_datapath
  import sdq_pkg::*;
#(
  parameter int DataW    = 16,
  parameter int NumBytes = 2,
  parameter int MaxLat   = SDQ_MAX_LAT,
  parameter int MaskDly  = 2,
  localparam int LaneW   = DataW / NumBytes
) (
  input  logic                clk,
  input  logic                rstN,
  input  pipeCtl_t            ctl,
  input  logic [DataW-1:0]    rdWord,
  input  logic [NumBytes-1:0] byteMask,
  input  logic                wrStb,
  input  logic [DataW-1:0]    wrWordIn,
  output logic [DataW-1:0]    dqOut,
  output logic [NumBytes-1:0] dqOe,
  output logic [DataW-1:0]    wrWordOut,
  output logic [NumBytes-1:0] wrByteEn
);

  logic [MaxLat-1:0]   validPipe;
  logic [DataW-1:0]    dataPipe [MaxLat];
  logic [NumBytes-1:0] maskPipe [MaskDly];
  logic                tapValid;
  logic [DataW-1:0]    tapWord;
  logic [NumBytes-1:0] laneMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe <= '0;
      for (int i = 0; i < MaxLat; i++) dataPipe[i] <= '0;
      for (int i = 0; i < MaskDly; i++) maskPipe[i] <= '0;
    end else begin
      validPipe   <= ctl.flushAll ? '0 : {validPipe[MaxLat-2:0], ctl.pushValid};
      dataPipe[0] <= rdWord;
      for (int i = 1; i < MaxLat; i++) dataPipe[i] <= dataPipe[i-1];
      maskPipe[0] <= byteMask;
      for (int i = 1; i < MaskDly; i++) maskPipe[i] <= maskPipe[i-1];
    end
  end

  always_comb begin
    tapValid = validPipe[ctl.tapSel];
    tapWord  = dataPipe[ctl.tapSel];
    laneMask = maskPipe[MaskDly-1];
  end

  for (genvar b = 0; b < NumBytes; b++) begin : g_lane
    assign dqOe[b]                 = tapValid & ~laneMask[b];
    assign dqOut[b*LaneW +: LaneW] = dqOe[b] ? tapWord[b*LaneW +: LaneW] : '0;
    assign wrByteEn[b]                 = wrStb & ~byteMask[b];
    assign wrWordOut[b*LaneW +: LaneW] = wrByteEn[b] ? wrWordIn[b*LaneW +: LaneW] : '0;

    // R4: a read mask floats its lane two edges later
    assert_read_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
      byteMask[b] |=> ##1 !dqOe[b]);
  end

  // R8: a write frees the bus on the next cycle
  assert_write_flush_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flushAll |=> (dqOe == '0));

endmodule

// File: rtl/sdram_rdlat_pipe.sv
module sdram_rdlat_pipe
  import sdq_pkg::*;
#(
  parameter int DataW    = 16,
  parameter int NumBytes = 2,
  parameter int CodeW    = 3,
  parameter int MinLat   = 2,
  parameter int MaxLat   = SDQ_MAX_LAT,
  parameter int MaskDly  = 2,
  localparam int LatW    = $clog2(MaxLat + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeLoad,
  input  logic [CodeW-1:0]    latCode,
  input  logic                rdWordValid,
  input  logic [DataW-1:0]    rdWord,
  input  logic [NumBytes-1:0] byteMask,
  input  logic                stopStb,
  input  logic                prechargeStb,
  input  logic                wrStb,
  input  logic [DataW-1:0]    wrWordIn,
  output logic [DataW-1:0]    dqOut,
  output logic [NumBytes-1:0] dqOe,
  output logic [DataW-1:0]    wrWordOut,
  output logic [NumBytes-1:0] wrByteEn
);

  pipeCtl_t        ctl;
  logic [LatW-1:0] curLat;

  sdq_ctrl #(
    .MinLat(MinLat), .MaxLat(MaxLat), .ResetLat(MaxLat), .CodeW(CodeW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .latCode(latCode),
    .rdWordValid(rdWordValid), .stopStb(stopStb), .prechargeStb(prechargeStb),
    .wrStb(wrStb), .ctl(ctl), .curLat(curLat)
  );

  sdq_datapath #(
    .DataW(DataW), .NumBytes(NumBytes), .MaxLat(MaxLat), .MaskDly(MaskDly)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdWord(rdWord), .byteMask(byteMask),
    .wrStb(wrStb), .wrWordIn(wrWordIn), .dqOut(dqOut), .dqOe(dqOe),
    .wrWordOut(wrWordOut), .wrByteEn(wrByteEn)
  );

  // R6, R7: cutoff one latency after a stop or precharge, latency 2
  assert_cut_lat2_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stopStb || prechargeStb) && (curLat == LatW'(2)) |=> ##1 (dqOe == '0));

  // R6, R7: cutoff one latency after a stop or precharge, latency 3
  assert_cut_lat3_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stopStb || prechargeStb) && (curLat == LatW'(3)) |=> ##2 (dqOe == '0));

endmodule

// File: tb/sdram_rdlat_pipe_bench.sv
module sdram_rdlat_pipe_bench;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeLoad = 1'b0;
  logic [2:0]  latCode = 3'b000;
  logic        rdWordValid = 1'b0;
  logic [15:0] rdWord = '0;
  logic [1:0]  byteMask = '0;
  logic        stopStb = 1'b0;
  logic        prechargeStb = 1'b0;
  logic        wrStb = 1'b0;
  logic [15:0] wrWordIn = '0;
  logic [15:0] dqOut;
  logic [1:0]  dqOe;
  logic [15:0] wrWordOut;
  logic [1:0]  wrByteEn;

  sdram_rdlat_pipe u_sdram_rdlat_pipe (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .latCode(latCode),
    .rdWordValid(rdWordValid), .rdWord(rdWord), .byteMask(byteMask),
    .stopStb(stopStb), .prechargeStb(prechargeStb), .wrStb(wrStb),
    .wrWordIn(wrWordIn), .dqOut(dqOut), .dqOe(dqOe),
    .wrWordOut(wrWordOut), .wrByteEn(wrByteEn)
  );

  always #(ClkPeriod/2) clk = ~clk;

  typedef struct { int cyc; logic [15:0] word; } expItem_t;
  expItem_t   expQ[$];
  logic [1:0] maskAt[int];
  int cyc = 0;
  int curLat = 3;
  int checks = 0;
  int errors = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // driver: one cycle of stimulus, sampled at the next rising edge
  task automatic drv(input logic v, input logic [15:0] w, input logic [1:0] m,
                     input logic stp, input logic pre, input logic wr,
                     input logic [15:0] wd);
    logic [1:0]  expEn;
    logic [15:0] expWo;
    int n;
    @(negedge clk);
    modeLoad = 1'b0; rdWordValid = v; rdWord = w; byteMask = m;
    stopStb = stp; prechargeStb = pre; wrStb = wr; wrWordIn = wd;
    n = cyc + 1;
    if (wr) while (expQ.size() > 0 && expQ[$].cyc >= n) void'(expQ.pop_back());
    if (v && !stp && !pre && !wr) expQ.push_back('{n + curLat - 1, w});
    if (m != 2'b00) maskAt[n] = m;
    #1;
    expEn = wr ? ~m : 2'b00;
    expWo = {expEn[1] ? wd[15:8] : 8'h00, expEn[0] ? wd[7:0] : 8'h00};
    chk(wrByteEn == expEn, "R5", "write byte enables", 32'(wrByteEn), 32'(expEn));
    chk(wrWordOut == expWo, "R5", "write data", 32'(wrWordOut), 32'(expWo));
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) drv(1'b0, 16'h0, 2'b00, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic setLat(input logic [2:0] code);
    @(negedge clk);
    modeLoad = 1'b1; latCode = code; rdWordValid = 1'b0; byteMask = '0;
    stopStb = 1'b0; prechargeStb = 1'b0; wrStb = 1'b0;
    if (code == 3'b010) curLat = 2;
    else if (code == 3'b011) curLat = 3;
  endtask

  task automatic burst(input int k, input logic [15:0] base);
    for (int i = 0; i < k; i++) drv(1'b1, base + 16'(i), 2'b00, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  // monitor: pops expected read words and compares every cycle
  initial begin
    forever begin
      logic [1:0]  mk;
      logic [1:0]  expOe;
      logic [15:0] word;
      logic [15:0] expDq;
      bit vld;
      @(posedge clk);
      cyc++;
      #1;
      if (monOn) begin
        vld = 1'b0; word = '0;
        if (expQ.size() > 0 && expQ[0].cyc == cyc) begin
          expItem_t it;
          it = expQ.pop_front();
          vld = 1'b1; word = it.word;
        end
        mk = maskAt.exists(cyc - 1) ? maskAt[cyc - 1] : 2'b00;
        expOe = {vld & ~mk[1], vld & ~mk[0]};
        expDq = {expOe[1] ? word[15:8] : 8'h00, expOe[0] ? word[7:0] : 8'h00};
        chk(dqOe == expOe, "R3,R4,R6,R7,R8", "read enables", 32'(dqOe), 32'(expOe));
        chk(dqOut == expDq, "R3,R4,R6,R7,R8", "read data", 32'(dqOut), 32'(expDq));
      end
    end
  end

  // watchdog
  initial begin
    #(ClkPeriod * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(dqOe == 2'b00, "R1", "enables in reset", 32'(dqOe), 32'h0);
    chk(dqOut == 16'h0, "R1", "data in reset", 32'(dqOut), 32'h0);
    rstN = 1'b1;
    monOn = 1'b1;
    idle(2);

    // R1, R3: default latency 3, one burst straight into another
    burst(4, 16'h1100);
    burst(3, 16'h2200);
    idle(5);

    // R2, R3: latency 2
    setLat(3'b010);
    burst(4, 16'h3300);
    idle(4);

    // R2: reserved codes ignored, latency stays 2
    setLat(3'b111);
    burst(2, 16'h4400);
    idle(4);
    setLat(3'b000);
    burst(2, 16'h4500);
    idle(4);

    // R2: back to latency 3
    setLat(3'b011);
    burst(3, 16'h5500);
    idle(5);

    // R4: read masks during a burst and on an idle cycle
    drv(1'b1, 16'hA1B1, 2'b10, 1'b0, 1'b0, 1'b0, 16'h0);
    drv(1'b1, 16'hA2B2, 2'b01, 1'b0, 1'b0, 1'b0, 16'h0);
    drv(1'b1, 16'hA3B3, 2'b11, 1'b0, 1'b0, 1'b0, 16'h0);
    drv(1'b1, 16'hA4B4, 2'b00, 1'b0, 1'b0, 1'b0, 16'h0);
    drv(1'b1, 16'hA5B5, 2'b00, 1'b0, 1'b0, 1'b0, 16'h0);
    drv(1'b0, 16'h0000, 2'b10, 1'b0, 1'b0, 1'b0, 16'h0);
    idle(5);

    // R6: burst stop at latency 3, word offered with the stop is dropped
    burst(3, 16'h6600);
    drv(1'b1, 16'h66FF, 2'b00, 1'b1, 1'b0, 1'b0, 16'h0);
    idle(5);

    // R6: burst stop at latency 2, then a fresh read right behind it
    setLat(3'b010);
    burst(3, 16'h7700);
    drv(1'b1, 16'h77FF, 2'b00, 1'b1, 1'b0, 1'b0, 16'h0);
    burst(2, 16'h7800);
    idle(4);

    // R7: precharge at latency 2 and at latency 3
    burst(3, 16'h8800);
    drv(1'b1, 16'h88FF, 2'b00, 1'b0, 1'b1, 1'b0, 16'h0);
    idle(4);
    setLat(3'b011);
    burst(3, 16'h9900);
    drv(1'b0, 16'h0000, 2'b00, 1'b0, 1'b1, 1'b0, 16'h0);
    idle(5);

    // R8, R5: write interrupts a read in flight, lower byte masked
    burst(3, 16'hC000);
    drv(1'b0, 16'h0000, 2'b01, 1'b0, 1'b0, 1'b1, 16'hBEEF);
    drv(1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b1, 16'h1234);
    drv(1'b0, 16'h0000, 2'b10, 1'b0, 1'b0, 1'b1, 16'h5678);
    idle(3);

    // R8: write at latency 2 right after a read word
    setLat(3'b010);
    burst(2, 16'hD000);
    drv(1'b0, 16'h0000, 2'b11, 1'b0, 1'b0, 1'b1, 16'hFFFF);
    idle(4);

    chk(expQ.size() == 0, "R3", "leftover expected words", 32'(expQ.size()), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule